// File: doc/BRIEF.md
# Lowest-Set-Bit Mask Execution Unit

This block is a small integer execution slice. It takes one source operand and returns a mask in which every bit from bit 0 up to and including the lowest 1 bit of the source is set, and every bit above it is clear. The mask is computed as (source − 1) XOR source. Alongside the mask it produces the carry, zero, sign and overflow flags.

The slice decides the operand width from the current processor mode and a width-select prefix bit. It raises an invalid-opcode fault when the operation is illegal, either because of the mode or because the vector-length prefix bit is set. A source is accepted on an input strobe. The result, flags and fault indication appear together one clock later, marked by a single-cycle output-valid pulse. A faulting operation leaves the result and the flags as they were.

Top module: `lsm_unit`

## Requirements
- R1: On a valid, non-faulting operation, the result is (source − 1) XOR source at the chosen width. It is a run of ones from bit 0 up to and including the lowest set source bit.
- R2: When the source is zero at the chosen width, the result is all ones at that width and carry is 1. In every other case carry is 0.
- R3: The sign flag equals bit 31 of the result for a 32-bit operation and bit 63 for a 64-bit operation.
- R4: The zero flag and the overflow flag are 0 after every non-faulting operation.
- R5: Mode encoding on `in_mode` is 0 = real, 1 = virtual-8086, 2 = 32-bit protected, 3 = 64-bit. In mode 2 the operation is always 32 bits wide, whatever the value of `in_wsel`.
- R6: In mode 3, `in_wsel` = 1 selects 64-bit operation and `in_wsel` = 0 selects 32-bit operation.
- R7: A 32-bit operation writes result bits 63..32 as zero.
- R8: When `in_vl` is 1, the operation pulses `out_fault` with `out_valid`, and the result and all four flags keep their previous values.
- R9: In mode 0 or mode 1, the operation pulses `out_fault` with `out_valid`, and the result and all four flags keep their previous values.
- R10: `out_valid` is high exactly one clock after each cycle with `in_valid` high and is low otherwise. Reset clears `out_valid`, `out_fault`, the result and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe; inputs are captured on this cycle |
| in_src | input | 64 | Source operand |
| in_mode | input | 2 | Processor mode (0 real, 1 virtual-8086, 2 32-bit protected, 3 64-bit) |
| in_wsel | input | 1 | Width-select prefix bit |
| in_vl | input | 1 | Vector-length prefix bit; must be 0 |
| out_valid | output | 1 | One-cycle pulse marking a completed operation |
| out_result | output | 64 | Mask result |
| out_carry | output | 1 | Carry flag (source was zero) |
| out_zero | output | 1 | Zero flag |
| out_sign | output | 1 | Sign flag |
| out_ovf | output | 1 | Overflow flag |
| out_fault | output | 1 | Invalid-opcode fault, valid with out_valid |

## Verification
A width decision latched wrongly shows up one clock after the strobe. The sign is then read from the wrong bit, or stray ones appear in bits 63..32, and both are visible in the same output cycle. A fault path that still updates the result register leaves a changed result or flag visible at the port in that same pulse cycle. A stale output-valid register shows as a pulse with no strobe one cycle earlier, or as a missing pulse.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode
  import lsm_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       wsel,
  input  logic       vl,
  output logic       fault,
  output logic       use_wide
);
  cpu_mode_e m;

  always_comb begin
    m        = cpu_mode_e'(mode);
    fault    = vl || (m == MODE_REAL) || (m == MODE_V86);
    use_wide = (m == MODE_LONG) && wsel;
  end
endmodule

// File: rtl/lsm_mask_core.sv
module lsm_mask_core #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] mask,
  output logic         top_bit,
  output logic         src_zero
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    mask     = (src - ONE) ^ src;
    top_bit  = mask[W-1];
    src_zero = (src == '0);
  end
endmodule

// File: rtl/lsm_unit.sv
module lsm_unit
  import lsm_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_src,
  input  logic [1:0]    in_mode,
  input  logic          in_wsel,
  input  logic          in_vl,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic          out_carry,
  output logic          out_zero,
  output logic          out_sign,
  output logic          out_ovf,
  output logic          out_fault
);
  localparam int HW = DW / 2;

  logic          dec_fault;
  logic          dec_wide;
  logic [DW-1:0] full_mask;
  logic [HW-1:0] half_mask;
  logic          full_top, half_top;
  logic          full_zero, half_zero;
  logic [DW-1:0] sel_mask;
  flags_t        sel_flags;
  flags_t        flags_q;
  logic          wide_q;

  lsm_decode u_decode (
    .mode     (in_mode),
    .wsel     (in_wsel),
    .vl       (in_vl),
    .fault    (dec_fault),
    .use_wide (dec_wide)
  );

  lsm_mask_core #(.W(DW)) u_core_full (
    .src      (in_src),
    .mask     (full_mask),
    .top_bit  (full_top),
    .src_zero (full_zero)
  );

  lsm_mask_core #(.W(HW)) u_core_half (
    .src      (in_src[HW-1:0]),
    .mask     (half_mask),
    .top_bit  (half_top),
    .src_zero (half_zero)
  );

  always_comb begin
    if (dec_wide) begin
      sel_mask        = full_mask;
      sel_flags.carry = full_zero;
      sel_flags.sign  = full_top;
    end else begin
      sel_mask        = {{HW{1'b0}}, half_mask};
      sel_flags.carry = half_zero;
      sel_flags.sign  = half_top;
    end
    sel_flags.zero = 1'b0;
    sel_flags.ovf  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_fault  <= 1'b0;
      out_result <= '0;
      flags_q    <= '0;
      wide_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_fault <= in_valid && dec_fault;
      if (in_valid && !dec_fault) begin
        out_result <= sel_mask;
        flags_q    <= sel_flags;
        wide_q     <= dec_wide;
      end
    end
  end

  assign out_carry = flags_q.carry;
  assign out_zero  = flags_q.zero;
  assign out_sign  = flags_q.sign;
  assign out_ovf   = flags_q.ovf;

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_mask_shape_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault) |->
      (((out_result & (out_result + DW'(1))) == '0) && (out_result != '0)));

  assert_carry_ones_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault && out_carry) |-> (&out_result[HW-1:0]));

  assert_sign_msb_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault) |->
      (out_sign == (wide_q ? out_result[DW-1] : out_result[HW-1])));

  assert_upper_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault && !wide_q) |-> (out_result[DW-1:HW] == '0));

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> ($stable(out_result) && $stable(flags_q)));

  assert_mode_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && ($past(in_mode) < 2'd2)) |-> out_fault);
endmodule

// File: tb/test_lsm_unit.sv
module test_lsm_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_src = '0;
  logic [1:0]  in_mode = 2'd3;
  logic        in_wsel = 1'b0;
  logic        in_vl = 1'b0;
  logic        out_valid, out_carry, out_zero, out_sign, out_ovf, out_fault;
  logic [63:0] out_result;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // reference state
  logic        e_valid = 0, e_fault = 0, e_carry = 0, e_sign = 0;
  logic [63:0] e_result = '0;
  string       e_tag = "R10";
  string       cur_tag = "R10";

  always #4 clk = ~clk;

  lsm_unit i_lsm_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
    .in_mode(in_mode), .in_wsel(in_wsel), .in_vl(in_vl),
    .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry),
    .out_zero(out_zero), .out_sign(out_sign), .out_ovf(out_ovf),
    .out_fault(out_fault)
  );

  // behavioural model: scan upward for the first 1 bit
  always @(posedge clk) begin
    int w;
    logic [63:0] r;
    if (rst) begin
      e_valid = 0; e_fault = 0; e_result = '0; e_carry = 0; e_sign = 0;
      e_tag = "R10";
    end else begin
      e_valid = in_valid;
      e_fault = 0;
      e_tag = cur_tag;
      if (in_valid) begin
        if (in_vl || in_mode < 2) begin
          e_fault = 1;
        end else begin
          w = (in_mode == 2'd3 && in_wsel) ? 64 : 32;
          r = '0;
          for (int i = 0; i < w; i++) begin
            r[i] = 1'b1;
            if (in_src[i]) break;
          end
          e_result = r;
          e_carry = 1'b1;
          for (int i = 0; i < w; i++) if (in_src[i]) e_carry = 1'b0;
          e_sign = r[w-1];
        end
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", e_tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk("valid", {63'b0, out_valid}, {63'b0, e_valid});
      chk("fault", {63'b0, out_fault}, {63'b0, e_fault});
      chk("result", out_result, e_result);
      chk("carry", {63'b0, out_carry}, {63'b0, e_carry});
      chk("sign", {63'b0, out_sign}, {63'b0, e_sign});
      chk("zero R4", {63'b0, out_zero}, 64'd0);
      chk("ovf R4", {63'b0, out_ovf}, 64'd0);
    end
  end

  task automatic issue(input string tag, input logic [63:0] src, input logic [1:0] mode,
                       input logic wsel, input logic vl);
    @(negedge clk);
    cur_tag = tag;
    in_valid = 1; in_src = src; in_mode = mode; in_wsel = wsel; in_vl = vl;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic burst(input string tag, input logic [63:0] src, input logic [1:0] mode,
                       input logic wsel, input logic vl);
    @(negedge clk);
    cur_tag = tag;
    in_valid = 1; in_src = src; in_mode = mode; in_wsel = wsel; in_vl = vl;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state checked by the per-cycle compare
    issue("R1", 64'h0000_0000_0000_0058, 2'd3, 1, 0);
    issue("R1", 64'h8000_0000_0000_0000, 2'd3, 1, 0);
    issue("R2", 64'h0, 2'd3, 1, 0);
    issue("R2", 64'h0, 2'd2, 0, 0);
    issue("R2", 64'hFFFF_FFFF_0000_0000, 2'd3, 0, 0);
    issue("R3", 64'h0000_0000_8000_0000, 2'd2, 0, 0);
    issue("R3", 64'h8000_0000_0000_0000, 2'd3, 1, 0);
    issue("R5", 64'h1234_0000_0000_0000, 2'd2, 1, 0);
    issue("R6", 64'h1234_0000_0000_0000, 2'd3, 1, 0);
    issue("R6", 64'h1234_0000_0000_0000, 2'd3, 0, 0);
    issue("R7", 64'hFFFF_FFFF_0001_0000, 2'd3, 0, 0);
    issue("R8", 64'h0000_0000_0000_0010, 2'd3, 1, 1);
    issue("R8", 64'h0, 2'd2, 0, 1);
    issue("R9", 64'h0, 2'd0, 1, 0);
    issue("R9", 64'h4, 2'd1, 0, 0);
    // back-to-back strobes, R10
    burst("R10", 64'h0000_0000_0000_0001, 2'd3, 1, 0);
    burst("R10", 64'h0000_0100_0000_0000, 2'd3, 1, 0);
    burst("R9", 64'h0000_0000_0000_0003, 2'd0, 0, 0);
    burst("R10", 64'h0000_0000_0000_0000, 2'd2, 1, 0);
    @(negedge clk); in_valid = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      cur_tag = "R1";
      in_valid = ($urandom_range(0, 3) != 0);
      in_src = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) in_src = in_src << $urandom_range(0, 63);
      if ($urandom_range(0, 15) == 0) in_src = '0;
      in_mode = 2'($urandom_range(0, 3));
      in_wsel = 1'($urandom_range(0, 1));
      in_vl = ($urandom_range(0, 9) == 0);
    end
    @(negedge clk); in_valid = 0;
    repeat (3) @(negedge clk);
    // R10: reset in mid-stream clears outputs
    rst = 1;
    @(negedge clk);
    cur_tag = "R10";
    @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule